// File: doc/BRIEF.md
# Precision Time Counter with Fractional Addend

This block keeps a 64-bit nanosecond time-of-day count for a timing-sensitive network datapath. While running, it advances once per clock cycle by a whole number of nanoseconds plus a 32-bit binary fraction of a nanosecond. Carries from the fraction add an extra nanosecond now and then, so the average rate can be trimmed in parts-per-billion steps. Software writes the addend as the low 32 bits of (2^32 × (10^9 + ppb)) / f_ref. The integer period field holds 10^9 / f_ref.

Besides the free-running count, the block forms a synchronized time. This is the count plus a programmable 64-bit offset, taken modulo 2^64, so a negative correction is stored as its two's-complement value. A "current time" view returns the synchronized time while counting is enabled, and a software-written default count while it is stopped. Every 64-bit value is read as two 32-bit words. Reading the low word freezes the matching high word, so software always sees a consistent pair. One read of the free-running low word also freezes the whole synchronized time.

Top module: `ptc_top`

## Requirements
- R1: After reset, the count, the fraction accumulator, the offset, the default count, the period, the addend, the enable bit and the read data are all zero.
- R2: While the enable bit (register 0, bit 0) is clear, the count does not change.
- R3: While enabled, each clock cycle adds the period (register 1, low PER_W bits) to the count, plus one more when the 32-bit fraction accumulator overflows on adding the addend (register 2). Starting from count 0 with the fraction at zero, after N cycles the count is N×P + floor(N×A / 2^32).
- R4: A write to register 3 replaces bits 31:0 of the count and clears the fraction accumulator. A write to register 4 replaces bits 63:32. A load takes the place of that cycle's increment.
- R5: Synchronized time equals the count plus the 64-bit offset, wrapping modulo 2^64. The offset's low half is register 5 and its high half is register 6.
- R6: Reading register 11 returns bits 31:0 of the free-running count. The same read snapshots bits 63:32 of the count and the full synchronized time. Registers 12, 13 and 14 then return the snapshot's free-running high word, synchronized low word and synchronized high word, and these stay fixed until the next read of register 11.
- R7: Reading register 9 returns the low word of the current time and latches its high word for register 10 until the next read of register 9. The current time is the synchronized time when enabled, and the default count (registers 7 low and 8 high) when disabled.
- R8: Read data appears on rdata after the clock edge that samples rd_en and holds until the next read. Reads of registers 0 to 8 and 15 return zero. Writes to registers 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one count step per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rdata | output | 32 | Registered read data |

## Verification
The step assertion assumes that the period field is not rewritten in the same cycle it is checked. It also assumes that the count is not loaded in the step it observes. The bench keeps to this by changing the configuration only while counting is stopped. The snapshot and latch assertions assume that only a low-word read may disturb a held word. The bench's running-snapshot test issues its reads of the held words at separate times. Expected counts come from the closed form N×P + floor(N×A / 2^32). The bench sweeps this over several addends, two periods and a range of cycle counts.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    localparam int WORD_W = 32;
    localparam int TIME_W = 2 * WORD_W;

    typedef enum logic [3:0] {
        RA_CTRL    = 4'd0,
        RA_PERIOD  = 4'd1,
        RA_ADDEND  = 4'd2,
        RA_CNT_LO  = 4'd3,
        RA_CNT_HI  = 4'd4,
        RA_OFF_LO  = 4'd5,
        RA_OFF_HI  = 4'd6,
        RA_DEF_LO  = 4'd7,
        RA_DEF_HI  = 4'd8,
        RA_CUR_LO  = 4'd9,
        RA_CUR_HI  = 4'd10,
        RA_FRT_LO  = 4'd11,
        RA_FRT_HI  = 4'd12,
        RA_SRT_LO  = 4'd13,
        RA_SRT_HI  = 4'd14
    } reg_addr_e;
endpackage

// File: rtl/ptc_accum.sv
module ptc_accum
    import ptc_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PER_W-1:0]  period,
    input  logic [WORD_W-1:0] addend,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [WORD_W-1:0] ld_data,
    output logic [TIME_W-1:0] count
);
    typedef struct packed {
        logic [WORD_W-1:0] frac;
        logic [TIME_W-1:0] cnt;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [WORD_W:0] frac_sum;

    always_comb begin
        acc_d    = acc_q;
        frac_sum = {1'b0, acc_q.frac} + {1'b0, addend};
        if (ld_lo || ld_hi) begin
            if (ld_lo) begin
                acc_d.cnt[WORD_W-1:0] = ld_data;
                acc_d.frac            = '0;
            end
            if (ld_hi) begin
                acc_d.cnt[TIME_W-1:WORD_W] = ld_data;
            end
        end else if (run) begin
            acc_d.frac = frac_sum[WORD_W-1:0];
            acc_d.cnt  = acc_q.cnt + TIME_W'(period) + TIME_W'(frac_sum[WORD_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign count = acc_q.cnt;

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_lo && !ld_hi) |=> $stable(acc_q.cnt));

    a_r3_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_lo && !ld_hi) |=>
            ((acc_q.cnt - $past(acc_q.cnt)) == TIME_W'($past(period)) ||
             (acc_q.cnt - $past(acc_q.cnt)) == TIME_W'($past(period)) + TIME_W'(1)));

    a_r4_frac_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (acc_q.frac == '0));
endmodule

// File: rtl/ptc_readout.sv
module ptc_readout
    import ptc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [3:0]        rd_addr,
    input  logic [TIME_W-1:0] frt,
    input  logic [TIME_W-1:0] srt,
    input  logic [TIME_W-1:0] cur,
    output logic [WORD_W-1:0] rdata
);
    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic [WORD_W-1:0] frt_hi;
        logic [TIME_W-1:0] srt_snap;
        logic [WORD_W-1:0] cur_hi;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            case (rd_addr)
                RA_FRT_LO: begin
                    rd_d.rdata    = frt[WORD_W-1:0];
                    rd_d.frt_hi   = frt[TIME_W-1:WORD_W];
                    rd_d.srt_snap = srt;
                end
                RA_FRT_HI: rd_d.rdata = rd_q.frt_hi;
                RA_SRT_LO: rd_d.rdata = rd_q.srt_snap[WORD_W-1:0];
                RA_SRT_HI: rd_d.rdata = rd_q.srt_snap[TIME_W-1:WORD_W];
                RA_CUR_LO: begin
                    rd_d.rdata  = cur[WORD_W-1:0];
                    rd_d.cur_hi = cur[TIME_W-1:WORD_W];
                end
                RA_CUR_HI: rd_d.rdata = rd_q.cur_hi;
                default:   rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.rdata;

    a_r6_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == RA_FRT_LO) |=> ($stable(rd_q.srt_snap) && $stable(rd_q.frt_hi)));

    a_r7_cur_high_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == RA_CUR_LO) |=> $stable(rd_q.cur_hi));

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr < 4'd9 || rd_addr == 4'd15)) |=> (rdata == '0));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/ptc_top.sv
module ptc_top
    import ptc_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rdata
);
    typedef struct packed {
        logic              run;
        logic [PER_W-1:0]  period;
        logic [WORD_W-1:0] addend;
        logic [TIME_W-1:0] offset;
        logic [TIME_W-1:0] dflt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [TIME_W-1:0] frt, srt, cur;
    logic ld_lo, ld_hi;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                RA_CTRL:   cfg_d.run    = wr_data[0];
                RA_PERIOD: cfg_d.period = wr_data[PER_W-1:0];
                RA_ADDEND: cfg_d.addend = wr_data;
                RA_OFF_LO: cfg_d.offset[WORD_W-1:0]      = wr_data;
                RA_OFF_HI: cfg_d.offset[TIME_W-1:WORD_W] = wr_data;
                RA_DEF_LO: cfg_d.dflt[WORD_W-1:0]        = wr_data;
                RA_DEF_HI: cfg_d.dflt[TIME_W-1:WORD_W]   = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ld_lo = wr_en && (wr_addr == RA_CNT_LO);
    assign ld_hi = wr_en && (wr_addr == RA_CNT_HI);

    ptc_accum #(.PER_W(PER_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_q.run),
        .period  (cfg_q.period),
        .addend  (cfg_q.addend),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_data (wr_data),
        .count   (frt)
    );

    assign srt = frt + cfg_q.offset;
    assign cur = cfg_q.run ? srt : cfg_q.dflt;

    ptc_readout u_readout (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .frt     (frt),
        .srt     (srt),
        .cur     (cur),
        .rdata   (rdata)
    );

    a_r7_default_view: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == RA_CUR_LO && !cfg_q.run) |=> (rdata == $past(cfg_q.dflt[WORD_W-1:0])));

    a_r5_snapshot_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == RA_FRT_LO) |=>
            (rdata == $past(frt[WORD_W-1:0])));
endmodule

// File: tb/ptc_top_test.sv
module ptc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ptc_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd64(input logic [3:0] lo_a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(lo_a, lo);
        rd(lo_a + 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hung expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] w;
        logic [63:0] v, v2;
        logic [31:0] addends [5];
        logic [7:0]  periods [2];
        addends[0] = 32'h0000_0000; addends[1] = 32'h8000_0000; addends[2] = 32'hFFFF_FFFF;
        addends[3] = 32'h4000_0001; addends[4] = 32'h0000_1234;
        periods[0] = 8'd20; periods[1] = 8'd7;

        repeat (3) @(negedge clk);
        check("R1 rdata after reset", {32'b0, rdata}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd64(4'd11, v);
        check("R1 free-running count", v, 64'd0);
        rd64(4'd9, v);
        check("R1 current view", v, 64'd0);
        rd64(4'd13, v);
        check("R1 synchronized time", v, 64'd0);

        wr(4'd1, 32'd20);
        rd(4'd1, w);
        check("R8 period register reads zero", {32'b0, w}, 64'd0);
        rd(4'd15, w);
        check("R8 unmapped reads zero", {32'b0, w}, 64'd0);

        // R3 sweep over addends, periods and step counts
        for (int pi = 0; pi < 2; pi++) begin
            for (int ai = 0; ai < 5; ai++) begin
                for (int nw = 0; nw < 8; nw++) begin
                    logic [63:0] n, exp;
                    wr(4'd1, {24'b0, periods[pi]});
                    wr(4'd2, addends[ai]);
                    wr(4'd3, 32'd0);
                    wr(4'd4, 32'd0);
                    wr(4'd0, 32'd1);
                    repeat (nw) @(negedge clk);
                    wr(4'd0, 32'd0);
                    n = 64'(nw + 1);
                    exp = n * 64'(periods[pi]) + ((n * 64'(addends[ai])) >> 32);
                    rd64(4'd11, v);
                    check($sformatf("R3 P=%0d A=%h N=%0d", periods[pi], addends[ai], n), v, exp);
                    if (nw == 3) begin
                        repeat (4) @(negedge clk);
                        rd64(4'd11, v2);
                        check("R2 count holds while stopped", v2, exp);
                    end
                end
            end
        end

        // R4 loads and carry across the word boundary
        wr(4'd1, 32'd20);
        wr(4'd2, 32'd0);
        wr(4'd3, 32'hFFFF_FFF0);
        wr(4'd4, 32'd5);
        rd64(4'd11, v);
        check("R4 loaded count", v, 64'h5_FFFF_FFF0);
        wr(4'd0, 32'd1);
        wr(4'd0, 32'd0);
        rd64(4'd11, v);
        check("R4 carry into high word", v, 64'h6_0000_0004);
        wr(4'd2, 32'h8000_0000);
        wr(4'd3, 32'd0);
        wr(4'd4, 32'd0);
        wr(4'd0, 32'd1);
        wr(4'd0, 32'd0);
        wr(4'd3, 32'd0);
        wr(4'd0, 32'd1);
        wr(4'd0, 32'd0);
        rd64(4'd11, v);
        check("R4 low load clears fraction", v, 64'd20);

        // R5 wrapping offset
        wr(4'd5, 32'hFFFF_FFFB);
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd3, 32'd3);
        rd(4'd11, w);
        rd64(4'd13, v);
        check("R5 negative offset wraps", v, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(4'd3, 32'd100);
        rd(4'd11, w);
        rd64(4'd13, v);
        check("R5 negative offset", v, 64'd95);
        wr(4'd5, 32'h0000_0010);
        wr(4'd6, 32'h0000_0002);
        rd(4'd11, w);
        rd64(4'd13, v);
        check("R5 positive offset", v, 64'h2_0000_0074);

        // R6 atomic snapshot while running
        wr(4'd5, 32'd0);
        wr(4'd6, 32'd0);
        wr(4'd2, 32'd0);
        wr(4'd3, 32'hFFFF_FF00);
        wr(4'd4, 32'd0);
        wr(4'd0, 32'd1);
        rd(4'd11, w);
        check("R6 snapshot low word", {32'b0, w}, 64'hFFFF_FF00);
        repeat (20) @(negedge clk);
        rd(4'd12, w);
        check("R6 frozen free-running high", {32'b0, w}, 64'd0);
        rd(4'd13, w);
        check("R6 frozen synchronized low", {32'b0, w}, 64'hFFFF_FF00);
        rd(4'd14, w);
        check("R6 frozen synchronized high", {32'b0, w}, 64'd0);
        rd(4'd11, w);
        rd(4'd12, w);
        check("R6 new snapshot high", {32'b0, w}, 64'd1);
        wr(4'd0, 32'd0);

        // R7 current view enabled and disabled
        wr(4'd3, 32'd0);
        wr(4'd4, 32'd0);
        wr(4'd5, 32'h10);
        wr(4'd0, 32'd1);
        repeat (4) @(negedge clk);
        rd(4'd9, w);
        check("R7 enabled view is synchronized", {32'b0, w}, 64'd96);
        rd(4'd10, w);
        check("R7 enabled view high", {32'b0, w}, 64'd0);
        wr(4'd0, 32'd0);
        wr(4'd7, 32'hAAAA_5555);
        wr(4'd8, 32'h0000_0BAD);
        rd64(4'd9, v);
        check("R7 disabled view is default", v, 64'h0BAD_AAAA_5555);

        // R8 writes to read-only addresses change nothing
        rd64(4'd11, v);
        wr(4'd11, 32'h1234_5678);
        wr(4'd12, 32'h1234_5678);
        wr(4'd9, 32'h1234_5678);
        rd64(4'd11, v2);
        check("R8 read-only write ignored (count)", v2, v);
        rd64(4'd9, v2);
        check("R8 read-only write ignored (view)", v2, 64'h0BAD_AAAA_5555);

        finished = 1'b1;
        summary();
    end
endmodule